// File: doc/BRIEF.md
# Min-Sum Check-Node State Updater

This block holds the compressed state of one check node in a column-layered min-sum LDPC decoder, and updates it one edge at a time. The state has an overall parity sign, the two smallest message magnitudes seen on the node's edges, and the edge index that supplied each of them. A column layer touches each edge in two steps. A remove command takes back the edge's previous variable-to-check message and returns the check-to-variable message for that edge. An insert command later folds the edge's freshly computed variable-to-check message into the state, ready for the next layer.

Commands arrive on one valid/ready stream with an opcode, an edge index and an 8-bit two's-complement message. Each remove command yields exactly one beat on a valid/ready output stream. An insert command yields no output beat. The output is a single register stage. While a beat is held because the consumer has not taken it, `in_ready` stays low, so back-pressure reaches the command source directly. A plain synchronous clear input returns the state to its empty value. The current state is visible at all times on plain outputs.

Top module: `mscn_state_updater`

## Requirements
- R1: After reset, and on the clock edge after `st_clear` is high, the state reads sign 0, both magnitudes 127 and both edge indices 0. Reset also leaves `out_valid` low.
- R2: A command is taken on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only when `st_clear` is low and either `out_valid` is low or `out_ready` is high. A beat that is held keeps `out_c2v` stable until it is taken.
- R3: A remove command (`in_op` = 0) XORs bit 7 of `in_msg`, the sign bit with 1 meaning negative, into the stored sign.
- R4: A remove command clears an entry by index, not by value. If `in_edge` equals the minimum's edge, the second minimum and its edge move into the minimum slot, and the second magnitude becomes 127 with its edge index unchanged. Otherwise, if `in_edge` equals the second minimum's edge, the second magnitude becomes 127. Otherwise no magnitude changes.
- R5: One cycle after a remove command is taken, `out_valid` is high. `out_c2v` then equals the reduced minimum, negated when the reduced sign is 1.
- R6: An insert command (`in_op` = 1) XORs the message sign into the state. It then sorts the message magnitude into the state. The magnitude is |msg|, and -128 is saturated to 127. If the magnitude is below the minimum, it becomes the minimum, and the old minimum with its edge moves to second place. Otherwise, if it is below the second minimum, it replaces the second minimum. A magnitude equal to a stored one leaves that entry in place.
- R7: An insert command produces no output beat.
- R8: The minimum never exceeds the second minimum, and `out_c2v` is never -128.
- R9: While `st_clear` is high, no command is taken. A command presented in that cycle does not change the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_clear | input | 1 | Synchronous return of the state to empty |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command can be taken |
| in_op | input | 1 | 0 remove, 1 insert |
| in_edge | input | EDGE_W | Edge index of the command |
| in_msg | input | MSG_W | Old (remove) or new (insert) variable-to-check message, two's complement |
| out_valid | output | 1 | Check-to-variable beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_c2v | output | MSG_W | Check-to-variable message, two's complement |
| st_sign | output | 1 | Stored parity sign, 1 negative |
| st_min1 | output | MSG_W-1 | Smallest stored magnitude |
| st_min2 | output | MSG_W-1 | Second smallest stored magnitude |
| st_min1_edge | output | EDGE_W | Edge that supplied the minimum |
| st_min2_edge | output | EDGE_W | Edge that supplied the second minimum |

## Verification
The assertions watch the properties that must hold on every cycle. These are the ordering of the two magnitudes, the absence of -128 at the output, a held beat staying stable while `in_ready` is low, and the empty state following a clear. The exact arithmetic of removal by index, promotion of the second minimum, saturation of -128 and tie handling on insert can only be seen through the bench's scenarios. In those scenarios the bench compares every state field and every check-to-variable value with a model computed from the rules above. This covers a sweep of every message value and long pseudo-random remove/insert sequences over eight edges.

// File: rtl/mscn_pkg.sv
package mscn_pkg;

  typedef enum logic {
    OP_REMOVE = 1'b0,
    OP_INSERT = 1'b1
  } cn_op_e;

endpackage

// File: rtl/mscn_msg_split.sv
module mscn_msg_split #(
  parameter int MSG_W = 8
) (
  input  logic [MSG_W-1:0] msg,
  output logic             sign,
  output logic [MSG_W-2:0] mag
);
  localparam int MAG_W = MSG_W - 1;
  localparam logic [MAG_W-1:0] MAX_MAG = {MAG_W{1'b1}};
  localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic [MSG_W-1:0] negated;

  always_comb begin
    sign    = msg[MSG_W-1];
    negated = -msg;
    if (!sign) begin
      mag = msg[MAG_W-1:0];
    end else if (msg == MOST_NEG) begin
      mag = MAX_MAG;
    end else begin
      mag = negated[MAG_W-1:0];
    end
  end
endmodule

// File: rtl/mscn_remove.sv
module mscn_remove #(
  parameter int MAG_W  = 7,
  parameter int EDGE_W = 5
) (
  input  logic              cur_sign,
  input  logic [MAG_W-1:0]  cur_min1,
  input  logic [MAG_W-1:0]  cur_min2,
  input  logic [EDGE_W-1:0] cur_e1,
  input  logic [EDGE_W-1:0] cur_e2,
  input  logic              rm_sign,
  input  logic [EDGE_W-1:0] rm_edge,
  output logic              nx_sign,
  output logic [MAG_W-1:0]  nx_min1,
  output logic [MAG_W-1:0]  nx_min2,
  output logic [EDGE_W-1:0] nx_e1,
  output logic [EDGE_W-1:0] nx_e2
);
  localparam logic [MAG_W-1:0] MAX_MAG = {MAG_W{1'b1}};

  always_comb begin
    nx_sign = cur_sign ^ rm_sign;
    nx_min1 = cur_min1;
    nx_min2 = cur_min2;
    nx_e1   = cur_e1;
    nx_e2   = cur_e2;
    if (rm_edge == cur_e1) begin
      // vacate the minimum: second place moves up, its slot empties
      nx_min1 = cur_min2;
      nx_e1   = cur_e2;
      nx_min2 = MAX_MAG;
    end else if (rm_edge == cur_e2) begin
      nx_min2 = MAX_MAG;
    end
  end
endmodule

// File: rtl/mscn_insert.sv
module mscn_insert #(
  parameter int MAG_W  = 7,
  parameter int EDGE_W = 5
) (
  input  logic              cur_sign,
  input  logic [MAG_W-1:0]  cur_min1,
  input  logic [MAG_W-1:0]  cur_min2,
  input  logic [EDGE_W-1:0] cur_e1,
  input  logic [EDGE_W-1:0] cur_e2,
  input  logic              ins_sign,
  input  logic [MAG_W-1:0]  ins_mag,
  input  logic [EDGE_W-1:0] ins_edge,
  output logic              nx_sign,
  output logic [MAG_W-1:0]  nx_min1,
  output logic [MAG_W-1:0]  nx_min2,
  output logic [EDGE_W-1:0] nx_e1,
  output logic [EDGE_W-1:0] nx_e2
);
  always_comb begin
    nx_sign = cur_sign ^ ins_sign;
    nx_min1 = cur_min1;
    nx_min2 = cur_min2;
    nx_e1   = cur_e1;
    nx_e2   = cur_e2;
    // strict compares: an equal magnitude never displaces a stored one
    if (ins_mag < cur_min1) begin
      nx_min2 = cur_min1;
      nx_e2   = cur_e1;
      nx_min1 = ins_mag;
      nx_e1   = ins_edge;
    end else if (ins_mag < cur_min2) begin
      nx_min2 = ins_mag;
      nx_e2   = ins_edge;
    end
  end
endmodule

// File: rtl/mscn_state_updater.sv
module mscn_state_updater
  import mscn_pkg::*;
#(
  parameter int MSG_W  = 8,
  parameter int EDGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_clear,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [EDGE_W-1:0] in_edge,
  input  logic [MSG_W-1:0]  in_msg,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [MSG_W-1:0]  out_c2v,
  output logic              st_sign,
  output logic [MSG_W-2:0]  st_min1,
  output logic [MSG_W-2:0]  st_min2,
  output logic [EDGE_W-1:0] st_min1_edge,
  output logic [EDGE_W-1:0] st_min2_edge
);
  localparam int MAG_W = MSG_W - 1;
  localparam logic [MAG_W-1:0] MAX_MAG  = {MAG_W{1'b1}};
  localparam logic [MSG_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

  logic              msg_sign;
  logic [MAG_W-1:0]  msg_mag;

  logic              rm_sign;
  logic [MAG_W-1:0]  rm_min1, rm_min2;
  logic [EDGE_W-1:0] rm_e1, rm_e2;

  logic              in_sign_n;
  logic [MAG_W-1:0]  in_min1_n, in_min2_n;
  logic [EDGE_W-1:0] in_e1_n, in_e2_n;

  logic              accept;
  logic              is_insert;
  logic [MSG_W-1:0]  c2v_mag;
  logic [MSG_W-1:0]  c2v_n;

  mscn_msg_split #(.MSG_W(MSG_W)) u_split (
    .msg  (in_msg),
    .sign (msg_sign),
    .mag  (msg_mag)
  );

  mscn_remove #(.MAG_W(MAG_W), .EDGE_W(EDGE_W)) u_remove (
    .cur_sign (st_sign),
    .cur_min1 (st_min1),
    .cur_min2 (st_min2),
    .cur_e1   (st_min1_edge),
    .cur_e2   (st_min2_edge),
    .rm_sign  (msg_sign),
    .rm_edge  (in_edge),
    .nx_sign  (rm_sign),
    .nx_min1  (rm_min1),
    .nx_min2  (rm_min2),
    .nx_e1    (rm_e1),
    .nx_e2    (rm_e2)
  );

  mscn_insert #(.MAG_W(MAG_W), .EDGE_W(EDGE_W)) u_insert (
    .cur_sign (st_sign),
    .cur_min1 (st_min1),
    .cur_min2 (st_min2),
    .cur_e1   (st_min1_edge),
    .cur_e2   (st_min2_edge),
    .ins_sign (msg_sign),
    .ins_mag  (msg_mag),
    .ins_edge (in_edge),
    .nx_sign  (in_sign_n),
    .nx_min1  (in_min1_n),
    .nx_min2  (in_min2_n),
    .nx_e1    (in_e1_n),
    .nx_e2    (in_e2_n)
  );

  always_comb begin
    in_ready  = !st_clear && (!out_valid || out_ready);
    accept    = in_valid && in_ready;
    is_insert = (cn_op_e'(in_op) == OP_INSERT);
    c2v_mag   = {1'b0, rm_min1};
    c2v_n     = rm_sign ? -c2v_mag : c2v_mag;
  end

  // node state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_sign      <= 1'b0;
      st_min1      <= MAX_MAG;
      st_min2      <= MAX_MAG;
      st_min1_edge <= '0;
      st_min2_edge <= '0;
    end else if (st_clear) begin
      st_sign      <= 1'b0;
      st_min1      <= MAX_MAG;
      st_min2      <= MAX_MAG;
      st_min1_edge <= '0;
      st_min2_edge <= '0;
    end else if (accept) begin
      if (is_insert) begin
        st_sign      <= in_sign_n;
        st_min1      <= in_min1_n;
        st_min2      <= in_min2_n;
        st_min1_edge <= in_e1_n;
        st_min2_edge <= in_e2_n;
      end else begin
        st_sign      <= rm_sign;
        st_min1      <= rm_min1;
        st_min2      <= rm_min2;
        st_min1_edge <= rm_e1;
        st_min2_edge <= rm_e2;
      end
    end
  end

  // output register stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_c2v   <= '0;
    end else begin
      if (out_valid && out_ready) begin
        out_valid <= 1'b0;
      end
      if (accept && !is_insert) begin
        out_valid <= 1'b1;
        out_c2v   <= c2v_n;
      end
    end
  end

  // R8: magnitudes stay ordered
  p_min_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_min1 <= st_min2);

  // R8: output never reaches the most negative code
  p_no_most_neg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_c2v != MOST_NEG));

  // R2: a held beat stays put and blocks new commands
  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_c2v)));

  p_stall_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R1: clear empties the state
  p_clear_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_clear |=> (!st_sign && st_min1 == MAX_MAG && st_min2 == MAX_MAG));

  // R7: an insert alone never raises a beat
  p_insert_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && is_insert && !out_valid) |=> !out_valid);

endmodule

// File: tb/test_mscn_state_updater.sv
module test_mscn_state_updater;
  localparam int MSG_W  = 8;
  localparam int EDGE_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              st_clear = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic              in_op = 1'b0;
  logic [EDGE_W-1:0] in_edge = '0;
  logic [MSG_W-1:0]  in_msg = '0;
  logic              out_valid;
  logic              out_ready = 1'b1;
  logic [MSG_W-1:0]  out_c2v;
  logic              st_sign;
  logic [MSG_W-2:0]  st_min1, st_min2;
  logic [EDGE_W-1:0] st_min1_edge, st_min2_edge;

  always #5 clk = ~clk;

  mscn_state_updater #(.MSG_W(MSG_W), .EDGE_W(EDGE_W)) i_mscn_state_updater (
    .clk(clk), .rst_n(rst_n), .st_clear(st_clear),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_edge(in_edge), .in_msg(in_msg),
    .out_valid(out_valid), .out_ready(out_ready), .out_c2v(out_c2v),
    .st_sign(st_sign), .st_min1(st_min1), .st_min2(st_min2),
    .st_min1_edge(st_min1_edge), .st_min2_edge(st_min2_edge)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_sign, m_min1, m_min2, m_e1, m_e2;
  int cur_msg [8];
  int lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mag_of(input int v);
    if (v == -128) return 127;
    return (v < 0) ? -v : v;
  endfunction

  task automatic model_clear();
    m_sign = 0; m_min1 = 127; m_min2 = 127; m_e1 = 0; m_e2 = 0;
  endtask

  task automatic check_state(input string req);
    chk(st_sign == m_sign[0], req, int'(st_sign), m_sign);
    chk(int'(st_min1) == m_min1, req, int'(st_min1), m_min1);
    chk(int'(st_min2) == m_min2, req, int'(st_min2), m_min2);
    chk(int'(st_min1_edge) == m_e1, req, int'(st_min1_edge), m_e1);
    chk(int'(st_min2_edge) == m_e2, req, int'(st_min2_edge), m_e2);
  endtask

  // called at a negedge; returns at the negedge after the accepting edge
  task automatic do_clear();
    st_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    st_clear = 1'b0;
    model_clear();
  endtask

  task automatic do_insert(input int edge_i, input int v, input string req);
    int mg;
    in_valid = 1'b1; in_op = 1'b1;
    in_edge = EDGE_W'(edge_i); in_msg = MSG_W'(v);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    mg = mag_of(v);
    m_sign = m_sign ^ (v < 0 ? 1 : 0);
    if (mg < m_min1) begin
      m_min2 = m_min1; m_e2 = m_e1; m_min1 = mg; m_e1 = edge_i;
    end else if (mg < m_min2) begin
      m_min2 = mg; m_e2 = edge_i;
    end
    check_state(req);
    chk(out_valid == 1'b0, "R7", int'(out_valid), 0);
  endtask

  task automatic do_remove(input int edge_i, input int v, input string req);
    int exp_c2v;
    in_valid = 1'b1; in_op = 1'b0;
    in_edge = EDGE_W'(edge_i); in_msg = MSG_W'(v);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    m_sign = m_sign ^ (v < 0 ? 1 : 0);
    if (edge_i == m_e1) begin
      m_min1 = m_min2; m_e1 = m_e2; m_min2 = 127;
    end else if (edge_i == m_e2) begin
      m_min2 = 127;
    end
    exp_c2v = m_sign ? -m_min1 : m_min1;
    check_state(req);
    chk(out_valid == 1'b1, "R5", int'(out_valid), 1);
    chk(int'($signed(out_c2v)) == exp_c2v, "R5", int'($signed(out_c2v)), exp_c2v);
  endtask

  function automatic int next_rand();
    lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
    return lfsr;
  endfunction

  initial begin
    #(10 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int hold_c2v;
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    check_state("R1");
    chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R2", int'(in_ready), 1);

    // R6 R3 R5: every message value as the minimum, then reading it back
    for (int v = -128; v < 128; v++) begin
      do_clear();
      do_insert(1, v, "R6");
      do_insert(2, 100, "R6");
      do_remove(2, 100, "R4");
      do_remove(1, v, "R3");
    end

    // R6: ties keep the earlier entry
    do_clear();
    do_insert(4, 5, "R6");
    do_insert(6, -5, "R6");
    do_insert(7, 5, "R6");
    // R4: removal by index, second slot only
    do_remove(6, -5, "R4");
    do_remove(9, 0, "R4");

    // R9: clear wins over a presented command
    in_valid = 1'b1; in_op = 1'b1; in_edge = 5'd3; in_msg = 8'd2;
    st_clear = 1'b1;
    #1;
    chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
    @(posedge clk);
    @(negedge clk);
    st_clear = 1'b0; in_valid = 1'b0;
    model_clear();
    check_state("R9");
    check_state("R1");

    // R2: back-pressure
    do_insert(2, -9, "R6");
    do_insert(3, 12, "R6");
    out_ready = 1'b0;
    do_remove(2, -9, "R2");
    hold_c2v = int'($signed(out_c2v));
    in_valid = 1'b1; in_op = 1'b1; in_edge = 5'd5; in_msg = 8'd1;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(in_ready == 1'b0, "R2", int'(in_ready), 0);
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == 1'b1, "R2", int'(out_valid), 1);
      chk(int'($signed(out_c2v)) == hold_c2v, "R2", int'($signed(out_c2v)), hold_c2v);
    end
    in_valid = 1'b0;
    check_state("R2");
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", int'(out_valid), 0);

    // R4 R8: pseudo-random column layers over eight edges
    do_clear();
    for (int e = 0; e < 8; e++) begin
      cur_msg[e] = (next_rand() % 256) - 128;
      do_insert(e, cur_msg[e], "R6");
    end
    for (int n = 0; n < 1500; n++) begin
      int e;
      int nv;
      e = next_rand() % 8;
      nv = (next_rand() % 256) - 128;
      do_remove(e, cur_msg[e], "R4");
      chk(st_min1 <= st_min2, "R8", int'(st_min1), int'(st_min2));
      do_insert(e, nv, "R6");
      cur_msg[e] = nv;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule